// File: doc/BRIEF.md
# Shared-Bus Wishbone Interconnect with Fixed-Priority Arbitration

This block joins several pipelined Wishbone masters to several slaves over one shared bus. At any time at most one master owns the bus. A small two-state arbiter hands ownership to the requesting master with the lowest index. The owner keeps the bus for the whole of its bus cycle, which lasts as long as it holds its cycle line high. No other master can take the bus during that time, even one with higher priority.

The owner's address is compared against a parameter table of slave windows. Each window is a base address and a mask, and the first window that matches selects the slave. The selected slave alone sees the cycle and strobe lines. Address, write data, write enable and byte selects go to every slave. The selected slave's acknowledge, error, stall and read data go back to the owner in the same cycle. A strobe to an address that matches no window is accepted at once and answered with an error one cycle later. The only registers are the grant state and that error flag. All routing is combinational.

Top module: `wb_shared_bus`

## Requirements
- R1: While reset is asserted, every master sees stall high and ack and err low, and every slave sees cyc and stb low, whatever the masters drive.
- R2: A master that raises cyc while the bus is idle is granted one clock later. Its stall is high in the cycle where its cyc is first seen, and its request reaches the slave from the next cycle.
- R3: When several masters request the idle bus in the same cycle, the one with the lowest index is granted.
- R4: The owner keeps the bus for as long as its cyc stays high. Requests from other masters, including higher-priority ones, do not take the bus away.
- R5: When the owner drops cyc, the bus is idle for exactly one cycle. In that cycle every master sees stall high. After that cycle the lowest-indexed master still requesting is granted.
- R6: Slave j is selected when (address AND mask_j) equals (base_j AND mask_j). With the defaults, addresses with top nibble 0x4 select slave 0 and addresses with top nibble 0x5 select slave 1. Only the selected slave sees cyc, and it sees stb only when the owner strobes. The other slaves see cyc and stb at 0.
- R7: The owner's address, write data, write enable and byte selects appear on the shared slave outputs in the same cycle.
- R8: The owner receives the selected slave's ack, err, stall and read data in the same cycle.
- R9: Every master that does not own the bus sees stall high and ack and err low.
- R10: A strobe from the owner to an address that matches no window reaches no slave and is not stalled. The owner sees err high in the next cycle, provided it still holds cyc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_cyc_i | input | NM | Cycle line of each master |
| m_stb_i | input | NM | Strobe of each master |
| m_we_i | input | NM | Write enable of each master |
| m_adr_i | input | NM*AW | Byte address of each master, master i at bits i*AW |
| m_dat_i | input | NM*DW | Write data of each master |
| m_sel_i | input | NM*(DW/8) | Byte selects of each master |
| m_dat_o | output | NM*DW | Read data returned to each master |
| m_ack_o | output | NM | Acknowledge to each master |
| m_err_o | output | NM | Error to each master |
| m_stall_o | output | NM | Stall to each master |
| s_cyc_o | output | NS | Cycle line of each slave |
| s_stb_o | output | NS | Strobe of each slave |
| s_we_o | output | 1 | Shared write enable |
| s_adr_o | output | AW | Shared address |
| s_dat_o | output | DW | Shared write data |
| s_sel_o | output | DW/8 | Shared byte selects |
| s_dat_i | input | NS*DW | Read data of each slave |
| s_ack_i | input | NS | Acknowledge of each slave |
| s_err_i | input | NS | Error of each slave |
| s_stall_i | input | NS | Stall of each slave |

## Verification
The bench uses the default parameters: three masters, two slaves, 32-bit address and data, and windows at 0x40000000 and 0x50000000, each 256 MB. With three masters, a lower-priority master can be shut out while two others hand the bus between them, and a higher-priority master can request while a lower one owns the bus. The top-nibble-0x7 region lies outside both windows, so the missing-slave error path can be reached with the same random address mix used for normal traffic.

// File: rtl/wbic_pkg.sv
package wbic_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;

  // Window hit: the bits under the mask agree between address and base.
  function automatic logic addr_in_window(input logic [63:0] adr,
                                          input logic [63:0] base,
                                          input logic [63:0] mask);
    return ((adr ^ base) & mask) == 64'd0;
  endfunction
endpackage

// File: rtl/wbic_arbiter.sv
module wbic_arbiter #(
  parameter int NM = 3,
  localparam int GW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NM-1:0] req_i,
  output logic          held_o,
  output logic [GW-1:0] gnt_o
);
  import wbic_pkg::*;

  arb_state_e    state_q;
  logic [GW-1:0] gnt_q;
  logic [GW-1:0] pick;
  logic          any_req;
  logic          owner_req;

  // Lowest-indexed requester wins.
  always_comb begin
    pick = '0;
    for (int i = NM - 1; i >= 0; i--) begin
      if (req_i[i]) pick = GW'(i);
    end
  end

  assign any_req   = |req_i;
  assign owner_req = req_i[gnt_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_IDLE;
      gnt_q   <= '0;
    end else begin
      unique case (state_q)
        ARB_IDLE: if (any_req) begin
          state_q <= ARB_HELD;
          gnt_q   <= pick;
        end
        ARB_HELD: if (!owner_req) state_q <= ARB_IDLE;
        default:  state_q <= ARB_IDLE;
      endcase
    end
  end

  assign held_o = (state_q == ARB_HELD);
  assign gnt_o  = gnt_q;

  // R3: a grant out of idle goes to the lowest requester of the previous cycle
  a_r3_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held_o && any_req) |=> (held_o && gnt_o == $past(pick)));
  // R4: ownership is kept while the owner holds cyc
  a_r4_hold_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && owner_req) |=> (held_o && $stable(gnt_o)));
  // R5: release of cyc returns the arbiter to idle
  a_r5_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held_o && !owner_req) |=> !held_o);
endmodule

// File: rtl/wbic_decoder.sv
module wbic_decoder #(
  parameter int             NS   = 2,
  parameter int             AW   = 32,
  parameter logic [NS*AW-1:0] BASE = {32'h5000_0000, 32'h4000_0000},
  parameter logic [NS*AW-1:0] MASK = {32'hF000_0000, 32'hF000_0000}
) (
  input  logic [AW-1:0] adr_i,
  output logic [NS-1:0] hit_o,
  output logic          miss_o
);
  import wbic_pkg::*;

  logic [NS-1:0] raw;

  for (genvar j = 0; j < NS; j++) begin : g_win
    assign raw[j] = addr_in_window(64'(adr_i), 64'(BASE[j*AW +: AW]),
                                   64'(MASK[j*AW +: AW]));
  end

  // First matching window takes the access.
  always_comb begin
    hit_o = '0;
    for (int j = NS - 1; j >= 0; j--) begin
      if (raw[j]) hit_o = NS'(1) << j;
    end
  end

  assign miss_o = ~|raw;
endmodule

// File: rtl/wbic_miss_resp.sv
module wbic_miss_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic own_i,
  output logic err_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= take_i;
  end

  assign err_o = pend_q & own_i;

  // R10: an accepted unmapped strobe is answered in the next cycle
  a_r10_miss_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (err_o || !own_i));
endmodule

// File: rtl/wb_shared_bus.sv
module wb_shared_bus #(
  parameter int NM = 3,
  parameter int NS = 2,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [NS*AW-1:0] SLV_BASE = {32'h5000_0000, 32'h4000_0000},
  parameter logic [NS*AW-1:0] SLV_MASK = {32'hF000_0000, 32'hF000_0000},
  localparam int SW = DW / 8,
  localparam int GW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NM-1:0]    m_cyc_i,
  input  logic [NM-1:0]    m_stb_i,
  input  logic [NM-1:0]    m_we_i,
  input  logic [NM*AW-1:0] m_adr_i,
  input  logic [NM*DW-1:0] m_dat_i,
  input  logic [NM*SW-1:0] m_sel_i,
  output logic [NM*DW-1:0] m_dat_o,
  output logic [NM-1:0]    m_ack_o,
  output logic [NM-1:0]    m_err_o,
  output logic [NM-1:0]    m_stall_o,
  output logic [NS-1:0]    s_cyc_o,
  output logic [NS-1:0]    s_stb_o,
  output logic             s_we_o,
  output logic [AW-1:0]    s_adr_o,
  output logic [DW-1:0]    s_dat_o,
  output logic [SW-1:0]    s_sel_o,
  input  logic [NS*DW-1:0] s_dat_i,
  input  logic [NS-1:0]    s_ack_i,
  input  logic [NS-1:0]    s_err_i,
  input  logic [NS-1:0]    s_stall_i
);
  logic          held;
  logic [GW-1:0] gnt;
  logic          own;
  logic          own_stb;
  logic [AW-1:0] g_adr;
  logic [DW-1:0] g_dat;
  logic [SW-1:0] g_sel;
  logic          g_we;
  logic          g_cyc;
  logic          g_stb;
  logic [NS-1:0] hit;
  logic          miss;
  logic          miss_take;
  logic          miss_err;
  logic          r_ack, r_err, r_stall;
  logic [DW-1:0] r_dat;

  wbic_arbiter #(.NM(NM)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (m_cyc_i),
    .held_o(held),
    .gnt_o (gnt)
  );

  // Forward path: pick the owner's fields.
  always_comb begin
    g_adr = '0; g_dat = '0; g_sel = '0; g_we = 1'b0; g_cyc = 1'b0; g_stb = 1'b0;
    for (int i = 0; i < NM; i++) begin
      if (gnt == GW'(i)) begin
        g_adr = m_adr_i[i*AW +: AW];
        g_dat = m_dat_i[i*DW +: DW];
        g_sel = m_sel_i[i*SW +: SW];
        g_we  = m_we_i[i];
        g_cyc = m_cyc_i[i];
        g_stb = m_stb_i[i];
      end
    end
  end

  assign own     = held & g_cyc;
  assign own_stb = own & g_stb;

  wbic_decoder #(.NS(NS), .AW(AW), .BASE(SLV_BASE), .MASK(SLV_MASK)) u_dec (
    .adr_i (g_adr),
    .hit_o (hit),
    .miss_o(miss)
  );

  assign s_cyc_o = own     ? hit : '0;
  assign s_stb_o = own_stb ? hit : '0;
  assign s_we_o  = g_we;
  assign s_adr_o = g_adr;
  assign s_dat_o = g_dat;
  assign s_sel_o = g_sel;

  assign miss_take = own_stb & miss;

  wbic_miss_resp u_miss (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .take_i(miss_take),
    .own_i (own),
    .err_o (miss_err)
  );

  // Return path: selected slave's response.
  assign r_ack   = |(s_ack_i & hit);
  assign r_err   = |(s_err_i & hit);
  assign r_stall = |(s_stall_i & hit);

  always_comb begin
    r_dat = '0;
    for (int j = 0; j < NS; j++) begin
      if (hit[j]) r_dat = r_dat | s_dat_i[j*DW +: DW];
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_mst
    logic is_owner;
    assign is_owner          = held && (gnt == GW'(i));
    assign m_ack_o[i]        = is_owner & r_ack;
    assign m_err_o[i]        = is_owner & (r_err | miss_err);
    assign m_stall_o[i]      = is_owner ? r_stall : 1'b1;
    assign m_dat_o[i*DW +: DW] = r_dat;

    // R9: masters without the bus are stalled and get no response
    a_r9_idle_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !is_owner |-> (m_stall_o[i] && !m_ack_o[i] && !m_err_o[i]));
  end

  // R6: at most one slave sees a cycle
  a_r6_one_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_cyc_o));
  // R6: a strobe only goes to a slave that also sees cyc
  a_r6_stb_in_cyc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_stb_o & ~s_cyc_o) == '0);
  // R9: exactly the owner can be unstalled, so at most one master at a time
  a_r9_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~m_stall_o) <= 1);
endmodule

// File: tb/wb_shared_bus_tb.sv
module wb_shared_bus_tb;
  localparam int NM = 3;
  localparam int NS = 2;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int SW = DW / 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NM-1:0]    m_cyc = '0, m_stb = '0, m_we = '0;
  logic [NM*AW-1:0] m_adr = '0;
  logic [NM*DW-1:0] m_dat = '0;
  logic [NM*SW-1:0] m_sel = '0;
  logic [NM*DW-1:0] m_dat_o;
  logic [NM-1:0]    m_ack, m_err, m_stall;
  logic [NS-1:0]    s_cyc, s_stb;
  logic             s_we;
  logic [AW-1:0]    s_adr;
  logic [DW-1:0]    s_dat_o;
  logic [SW-1:0]    s_sel;
  logic [NS*DW-1:0] s_dat = '0;
  logic [NS-1:0]    s_ack = '0, s_err = '0, s_stall = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  wb_shared_bus u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_adr_i(m_adr),
    .m_dat_i(m_dat), .m_sel_i(m_sel), .m_dat_o(m_dat_o), .m_ack_o(m_ack),
    .m_err_o(m_err), .m_stall_o(m_stall), .s_cyc_o(s_cyc), .s_stb_o(s_stb),
    .s_we_o(s_we), .s_adr_o(s_adr), .s_dat_o(s_dat_o), .s_sel_o(s_sel),
    .s_dat_i(s_dat), .s_ack_i(s_ack), .s_err_i(s_err), .s_stall_i(s_stall)
  );

  // Reference model of ownership, updated on the clock from the inputs.
  logic       x_held = 1'b0;
  int         x_g = 0;
  logic       x_miss = 1'b0;

  // Window index by top nibble: 0x4 -> 0, 0x5 -> 1, else none (NS).
  function automatic int slave_of(input logic [AW-1:0] a);
    if (a[31:28] == 4'h4) return 0;
    if (a[31:28] == 4'h5) return 1;
    return NS;
  endfunction

  function automatic int first_req(input logic [NM-1:0] c);
    for (int i = 0; i < NM; i++) if (c[i]) return i;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_held <= 1'b0; x_g <= 0; x_miss <= 1'b0;
    end else begin
      x_miss <= x_held && m_cyc[x_g] && m_stb[x_g] &&
                (slave_of(m_adr[x_g*AW +: AW]) == NS);
      if (!x_held) begin
        if (|m_cyc) begin x_held <= 1'b1; x_g <= first_req(m_cyc); end
      end else if (!m_cyc[x_g]) begin
        x_held <= 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Full comparison against the model for the current cycle.
  task automatic compare_model();
    logic [AW-1:0] ga;
    int            sl;
    logic          own;
    logic [NS-1:0] ecyc, estb;
    ga  = m_adr[x_g*AW +: AW];
    sl  = slave_of(ga);
    own = x_held && m_cyc[x_g];
    ecyc = '0; estb = '0;
    if (own && sl < NS) begin
      ecyc[sl] = 1'b1;
      estb[sl] = m_stb[x_g];
    end
    check("R6 slave cyc", 64'(s_cyc), 64'(ecyc));
    check("R6 slave stb", 64'(s_stb), 64'(estb));
    if (own) begin
      check("R7 address", 64'(s_adr), 64'(ga));
      check("R7 wdata", 64'(s_dat_o), 64'(m_dat[x_g*DW +: DW]));
      check("R7 we/sel", 64'({s_we, s_sel}), 64'({m_we[x_g], m_sel[x_g*SW +: SW]}));
    end
    for (int i = 0; i < NM; i++) begin
      if (x_held && i == x_g) begin
        logic ea, ee, es;
        logic [DW-1:0] ed;
        ea = (sl < NS) ? s_ack[sl] : 1'b0;
        ee = ((sl < NS) ? s_err[sl] : 1'b0) | (x_miss & m_cyc[i]);
        es = (sl < NS) ? s_stall[sl] : 1'b0;
        ed = (sl < NS) ? s_dat[sl*DW +: DW] : '0;
        check("R8 ack", 64'(m_ack[i]), 64'(ea));
        check("R8/R10 err", 64'(m_err[i]), 64'(ee));
        check("R8 stall", 64'(m_stall[i]), 64'(es));
        check("R8 rdata", 64'(m_dat_o[i*DW +: DW]), 64'(ed));
      end else begin
        check("R9 other master", 64'({m_stall[i], m_ack[i], m_err[i]}), 64'(3'b100));
      end
    end
  endtask

  task automatic set_adr(input int i, input logic [AW-1:0] a);
    m_adr[i*AW +: AW] = a;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    void'($urandom(32'd12345));
    // R1: reset holds everything quiet even with requests present
    m_cyc = '1; m_stb = '1;
    set_adr(0, 32'h4000_0000);
    repeat (3) @(negedge clk);
    #1;
    check("R1 stall in reset", 64'(m_stall), 64'(3'b111));
    check("R1 ack/err in reset", 64'({m_ack, m_err}), 64'(0));
    check("R1 slave cyc/stb in reset", 64'({s_cyc, s_stb}), 64'(0));
    @(negedge clk);
    m_cyc = '0; m_stb = '0;
    rst_n = 1'b1;

    // R2/R3: masters 1 and 2 request together
    @(negedge clk);
    m_cyc = 3'b110; m_stb = 3'b110;
    set_adr(1, 32'h4000_0010); set_adr(2, 32'h5000_0000);
    #1;
    check("R2 no grant in first cycle", 64'(m_stall), 64'(3'b111));
    check("R2 no slave cyc yet", 64'(s_cyc), 64'(0));
    @(negedge clk); #1;
    check("R3 master1 wins", 64'(m_stall), 64'(3'b101));
    check("R2 slave0 selected", 64'(s_cyc), 64'(2'b01));
    check("R7 owner address", 64'(s_adr), 64'(32'h4000_0010));

    // R4: higher priority master 0 arrives, owner keeps the bus
    @(negedge clk);
    m_cyc = 3'b111;
    s_ack = 2'b01; s_dat = {32'h0, 32'hA5A5_5A5A};
    #1;
    check("R4 owner kept", 64'(m_stall), 64'(3'b101));
    check("R8 ack routed", 64'(m_ack), 64'(3'b010));
    check("R8 rdata routed", 64'(m_dat_o[1*DW +: DW]), 64'(32'hA5A5_5A5A));

    // R5: owner releases, one idle cycle, then master 0
    @(negedge clk);
    m_cyc = 3'b101; s_ack = '0;
    set_adr(0, 32'h5000_0100);
    #1;
    check("R5 released owner reaches no slave", 64'(s_cyc), 64'(0));
    check("R4 master0 still waits", 64'(m_stall[0]), 64'(1));
    @(negedge clk); #1;
    check("R5 idle gap", 64'(m_stall), 64'(3'b111));
    @(negedge clk); #1;
    check("R5 master0 granted", 64'(m_stall), 64'(3'b110));
    check("R6 slave1 selected", 64'(s_cyc), 64'(2'b10));

    // R10: unmapped address
    @(negedge clk);
    m_stb = 3'b001;
    set_adr(0, 32'h7000_0004);
    #1;
    check("R10 no slave for miss", 64'({s_cyc, s_stb}), 64'(0));
    check("R10 miss not stalled", 64'(m_stall[0]), 64'(0));
    check("R10 no early err", 64'(m_err), 64'(0));
    @(negedge clk);
    m_stb = '0;
    #1;
    check("R10 err next cycle", 64'(m_err), 64'(3'b001));
    @(negedge clk); #1;
    check("R10 single err", 64'(m_err), 64'(0));

    @(negedge clk);
    m_cyc = '0;
    repeat (2) @(negedge clk);

    // Random traffic against the reference model
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      for (int i = 0; i < NM; i++) begin
        int sel;
        if ($urandom_range(7) == 0) m_cyc[i] = ~m_cyc[i];
        m_stb[i] = m_cyc[i] & $urandom_range(1);
        m_we[i]  = $urandom_range(1);
        sel = $urandom_range(4);
        set_adr(i, {(sel < 2) ? 4'h4 : (sel < 4) ? 4'h5 : 4'h7, 28'($urandom)});
        m_dat[i*DW +: DW] = $urandom;
        m_sel[i*SW +: SW] = SW'($urandom);
      end
      s_ack   = NS'($urandom);
      s_err   = NS'($urandom);
      s_stall = NS'($urandom);
      for (int j = 0; j < NS; j++) s_dat[j*DW +: DW] = $urandom;
      #1;
      compare_model();
    end
    finish_run();
  end
endmodule